// File: doc/BRIEF.md
# Clock Post-Divider Calculator

This block picks the integer post-divider that turns a VCO frequency into an output clock no faster than a requested target. After a start strobe it takes two unsigned operands in the same unit, the VCO frequency and the target frequency. It then returns three results: the divider it chose, the output frequency that divider actually gives, and a flag that says whether the request could be met. A single-cycle done pulse marks the moment all of these are valid.

The work is done by one shared multi-cycle restoring divider that runs twice. The first run divides the VCO frequency by the target. Its quotient and remainder give the smallest divider whose output does not exceed the target. That divider is then made even when it is above a parameterised threshold and odd, and checked against the largest value the divider field can hold. The second run divides the VCO frequency by the final divider to give the achieved frequency. Requests that cannot succeed fail in one cycle and never start the divider: a zero target, or a VCO frequency below the target.

Top module: `pdiv_calc`

## Requirements
- R1: If the VCO frequency is below the target, the result is an error: `err_o`=1, `ok_o`=0, `div_o`=0, `freq_o`=0.
- R2: A target of zero gives the same error result as R1, with no division attempted.
- R3: The divider starts as floor(VCO/target) and is raised by one when floor(VCO/divider) would still exceed the target, so on success `freq_o` <= target.
- R4: A divider greater than 5 (parameter `EVEN_ABOVE`) that is odd is raised by one, so every successful divider above 5 is even.
- R5: A final divider of 128 (2^`DW`) or more is reported as an error with `div_o`=0 and `freq_o`=0. A successful divider is never 0.
- R6: On success, `freq_o` equals floor(VCO / `div_o`), truncated.
- R7: Each accepted start produces exactly one `done_o` cycle, and in that cycle exactly one of `ok_o` and `err_o` is high.
- R8: A start that arrives while a request is in progress is ignored. The outputs keep their values in every cycle in which `done_o` is low.
- R9: `done_o` rises no more than 2*W/UNROLL+2 clock edges after the edge that accepts the start (66 with the defaults). A rejected input takes one edge.
- R10: After reset `done_o`, `ok_o`, `err_o`, `div_o` and `freq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe; taken only when idle |
| vco_i | input | W (32) | VCO frequency, sampled at the accepted start |
| target_i | input | W (32) | Target output frequency, sampled at the accepted start |
| done_o | output | 1 | One-cycle result strobe |
| ok_o | output | 1 | Result is a usable divider |
| err_o | output | 1 | Request could not be met |
| div_o | output | DW (7) | Chosen post-divider |
| freq_o | output | W (32) | Achieved frequency, VCO / divider |

## Verification
The checker keeps its own record of when a start is accepted: the first strobe with no request pending, or a strobe in the same cycle as `done_o`. It also keeps its own copy of the operands. It therefore assumes the operands are meaningful only at that acceptance, and that reset is held across at least one rising edge. The stimulus drives start for one cycle per request and then waits for the result before the next one. There is one deliberate exception: a second strobe with different operands is sent during a valid request, and the scoreboard expects no result for it. Operands are chosen so that the product of achieved frequency and divider stays inside the checker's widened arithmetic. Many random cases are built as target times a small multiplier plus a remainder, which keeps the divider near the 128 boundary.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

   // Sequencer phases of one request
   typedef enum logic [1:0] {
      PD_IDLE = 2'd0,   // waiting for start
      PD_QUOT = 2'd1,   // first division: VCO / target
      PD_ACH  = 2'd2    // second division: VCO / final divider
   } pd_state_e;

endpackage

// File: rtl/pdiv_udiv.sv
// Iterative restoring unsigned divider, UNROLL quotient bits per clock.
module pdiv_udiv #(
   parameter int W      = 32,
   parameter int UNROLL = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go_i,
   input  logic [W-1:0] dividend_i,
   input  logic [W-1:0] divisor_i,
   output logic         done_o,
   output logic [W-1:0] quo_o,
   output logic [W-1:0] rem_o
);
   localparam int STEPS = W / UNROLL;
   localparam int CW    = $clog2(STEPS + 1);

   generate
      if (UNROLL < 1 || (W % UNROLL) != 0) begin : g_bad_unroll
         $error("pdiv_udiv: UNROLL must divide W");
      end
   endgenerate

   logic [W-1:0]  quo_q, rem_q, dsr_q;
   logic [CW-1:0] cnt_q;
   logic          run_q;

   logic [W-1:0] quo_s [0:UNROLL];
   logic [W-1:0] rem_s [0:UNROLL];

   assign quo_s[0] = quo_q;
   assign rem_s[0] = rem_q;

   // One restoring step per stage; the chain length picks bits per cycle
   generate
      for (genvar i = 0; i < UNROLL; i++) begin : g_step
         logic [W:0] trial;
         logic [W:0] diff;
         logic       fits;
         assign trial        = {rem_s[i], quo_s[i][W-1]};
         assign diff         = trial - {1'b0, dsr_q};
         assign fits         = trial >= {1'b0, dsr_q};
         assign rem_s[i+1]   = fits ? diff[W-1:0] : trial[W-1:0];
         assign quo_s[i+1]   = {quo_s[i][W-2:0], fits};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         quo_q  <= '0;
         rem_q  <= '0;
         dsr_q  <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (go_i) begin
            quo_q <= dividend_i;
            rem_q <= '0;
            dsr_q <= divisor_i;
            cnt_q <= CW'(STEPS);
            run_q <= 1'b1;
         end else if (run_q) begin
            quo_q <= quo_s[UNROLL];
            rem_q <= rem_s[UNROLL];
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               run_q  <= 1'b0;
               done_o <= 1'b1;
            end
         end
      end
   end

   assign quo_o = quo_q;
   assign rem_o = rem_q;

endmodule

// File: rtl/pdiv_round.sv
// Turns the first quotient/remainder into the final divider.
// floor(V/q) > T  <=>  V >= q*(T+1)  <=>  rem >= q   (V = q*T + rem)
module pdiv_round #(
   parameter int W          = 32,
   parameter int DW         = 7,
   parameter int EVEN_ABOVE = 5,
   parameter bit FORCE_EVEN = 1'b1
) (
   input  logic [W-1:0]  quo_i,
   input  logic [W-1:0]  rem_i,
   output logic [DW-1:0] div_o,
   output logic          range_err_o
);
   localparam logic [W:0] LIMIT   = (W+1)'(1) << DW;
   localparam logic [W:0] EVEN_TH = (W+1)'(EVEN_ABOVE);

   logic [W:0] base;
   logic [W:0] adj;

   assign base = {1'b0, quo_i} + {{W{1'b0}}, (rem_i >= quo_i)};

   generate
      if (FORCE_EVEN) begin : g_even
         assign adj = (base > EVEN_TH && base[0]) ? base + (W+1)'(1) : base;
      end else begin : g_plain
         assign adj = base;
      end
   endgenerate

   assign range_err_o = adj >= LIMIT;
   assign div_o       = adj[DW-1:0];

endmodule

// File: rtl/pdiv_seq.sv
// Request sequencer: input screening, divider launches, result registers.
module pdiv_seq
   import pdiv_pkg::*;
#(
   parameter int W  = 32,
   parameter int DW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [W-1:0]  vco_i,
   input  logic [W-1:0]  tgt_i,
   input  logic          udiv_done_i,
   input  logic [W-1:0]  udiv_quo_i,
   input  logic [DW-1:0] rnd_div_i,
   input  logic          rnd_err_i,
   output logic          go_o,
   output logic [W-1:0]  dvd_o,
   output logic [W-1:0]  dsr_o,
   output logic          done_o,
   output logic          ok_o,
   output logic          err_o,
   output logic [DW-1:0] div_o,
   output logic [W-1:0]  freq_o
);
   pd_state_e     state_q;
   logic [W-1:0]  vco_q;
   logic [DW-1:0] div_q;
   logic          in_bad;
   logic          idle;

   assign idle   = (state_q == PD_IDLE);
   assign in_bad = (tgt_i == '0) || (vco_i < tgt_i);
   assign go_o   = (idle && start_i && !in_bad) ||
                   (state_q == PD_QUOT && udiv_done_i && !rnd_err_i);
   assign dvd_o  = idle ? vco_i : vco_q;
   assign dsr_o  = idle ? tgt_i : {{(W-DW){1'b0}}, rnd_div_i};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PD_IDLE;
         vco_q   <= '0;
         div_q   <= '0;
         done_o  <= 1'b0;
         ok_o    <= 1'b0;
         err_o   <= 1'b0;
         div_o   <= '0;
         freq_o  <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            PD_IDLE: begin
               if (start_i) begin
                  vco_q <= vco_i;
                  if (in_bad) begin
                     done_o <= 1'b1;
                     ok_o   <= 1'b0;
                     err_o  <= 1'b1;
                     div_o  <= '0;
                     freq_o <= '0;
                  end else begin
                     state_q <= PD_QUOT;
                  end
               end
            end
            PD_QUOT: begin
               if (udiv_done_i) begin
                  if (rnd_err_i) begin
                     done_o  <= 1'b1;
                     ok_o    <= 1'b0;
                     err_o   <= 1'b1;
                     div_o   <= '0;
                     freq_o  <= '0;
                     state_q <= PD_IDLE;
                  end else begin
                     div_q   <= rnd_div_i;
                     state_q <= PD_ACH;
                  end
               end
            end
            PD_ACH: begin
               if (udiv_done_i) begin
                  done_o  <= 1'b1;
                  ok_o    <= 1'b1;
                  err_o   <= 1'b0;
                  div_o   <= div_q;
                  freq_o  <= udiv_quo_i;
                  state_q <= PD_IDLE;
               end
            end
            default: state_q <= PD_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pdiv_calc.sv
module pdiv_calc #(
   parameter int W          = 32,
   parameter int DW         = 7,
   parameter int EVEN_ABOVE = 5,
   parameter bit FORCE_EVEN = 1'b1,
   parameter int UNROLL     = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [W-1:0]  vco_i,
   input  logic [W-1:0]  target_i,
   output logic          done_o,
   output logic          ok_o,
   output logic          err_o,
   output logic [DW-1:0] div_o,
   output logic [W-1:0]  freq_o
);
   generate
      if (DW < 2 || DW >= W) begin : g_bad_dw
         $error("pdiv_calc: DW must be in 2..W-1");
      end
      if (EVEN_ABOVE < 0 || EVEN_ABOVE >= (1 << DW)) begin : g_bad_even
         $error("pdiv_calc: EVEN_ABOVE outside divider range");
      end
   endgenerate

   logic          go;
   logic [W-1:0]  dvd, dsr, quo, rem;
   logic          udiv_done;
   logic [DW-1:0] rnd_div;
   logic          rnd_err;

   pdiv_udiv #(.W(W), .UNROLL(UNROLL)) u_udiv (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_i       (go),
      .dividend_i (dvd),
      .divisor_i  (dsr),
      .done_o     (udiv_done),
      .quo_o      (quo),
      .rem_o      (rem)
   );

   pdiv_round #(
      .W(W), .DW(DW), .EVEN_ABOVE(EVEN_ABOVE), .FORCE_EVEN(FORCE_EVEN)
   ) u_round (
      .quo_i       (quo),
      .rem_i       (rem),
      .div_o       (rnd_div),
      .range_err_o (rnd_err)
   );

   pdiv_seq #(.W(W), .DW(DW)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .vco_i       (vco_i),
      .tgt_i       (target_i),
      .udiv_done_i (udiv_done),
      .udiv_quo_i  (quo),
      .rnd_div_i   (rnd_div),
      .rnd_err_i   (rnd_err),
      .go_o        (go),
      .dvd_o       (dvd),
      .dsr_o       (dsr),
      .done_o      (done_o),
      .ok_o        (ok_o),
      .err_o       (err_o),
      .div_o       (div_o),
      .freq_o      (freq_o)
   );

endmodule

// File: rtl/pdiv_calc_chk.sv
module pdiv_calc_chk #(
   parameter int W          = 32,
   parameter int DW         = 7,
   parameter int EVEN_ABOVE = 5,
   parameter int UNROLL     = 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic [W-1:0]  vco_i,
   input logic [W-1:0]  target_i,
   input logic          done_o,
   input logic          ok_o,
   input logic          err_o,
   input logic [DW-1:0] div_o,
   input logic [W-1:0]  freq_o
);
   localparam int LAT_MAX = 2 * (W / UNROLL) + 2;
   localparam int LW      = $clog2(LAT_MAX + 2);
   localparam int PW      = W + DW + 1;

   logic          pend_q;
   logic [W-1:0]  vco_l, tgt_l;
   logic [LW-1:0] lat_q;
   logic [PW-1:0] prod_lo, prod_hi, vco_w;

   assign prod_lo = PW'(freq_o) * PW'(div_o);
   assign prod_hi = prod_lo + PW'(div_o);
   assign vco_w   = PW'(vco_l);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         vco_l  <= '0;
         tgt_l  <= '0;
         lat_q  <= '0;
      end else begin
         if (done_o) pend_q <= 1'b0;
         else if (pend_q && lat_q != '1) lat_q <= lat_q + 1'b1;
         if (start_i && (!pend_q || done_o)) begin
            pend_q <= 1'b1;
            vco_l  <= vco_i;
            tgt_l  <= target_i;
            lat_q  <= '0;
         end
      end
   end

   p_below_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && (vco_l < tgt_l) |-> err_o && !ok_o && div_o == '0 && freq_o == '0);

   p_zero_tgt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && tgt_l == '0 |-> err_o && !ok_o);

   p_not_above_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && ok_o |-> freq_o <= tgt_l);

   p_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && ok_o && div_o > DW'(EVEN_ABOVE) |-> !div_o[0]);

   p_div_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && ok_o |-> div_o != '0);

   p_truncated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && ok_o |-> prod_lo <= vco_w && prod_hi > vco_w);

   p_one_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ok_o ^ err_o);

   p_done_owned_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> pend_q);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable({ok_o, err_o, div_o, freq_o}));

   p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> lat_q <= LW'(LAT_MAX));

endmodule

bind pdiv_calc pdiv_calc_chk #(
   .W(W), .DW(DW), .EVEN_ABOVE(EVEN_ABOVE), .UNROLL(UNROLL)
) u_chk (.*);

// File: tb/pdiv_calc_bench.sv
`timescale 1ns/1ps
module pdiv_calc_bench;
   localparam int W       = 32;
   localparam int DW      = 7;
   localparam int LAT_MAX = 2 * W + 2;

   typedef struct {
      bit            err;
      bit [DW-1:0]   div;
      bit [W-1:0]    freq;
      string         req;
      int            t0;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [W-1:0]  vco_i = '0;
   logic [W-1:0]  target_i = '0;
   logic          done_o, ok_o, err_o;
   logic [DW-1:0] div_o;
   logic [W-1:0]  freq_o;

   int   n_chk = 0;
   int   n_bad = 0;
   int   cyc   = 0;
   exp_t sb[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pdiv_calc u_pdiv_calc (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .vco_i(vco_i),
      .target_i(target_i), .done_o(done_o), .ok_o(ok_o), .err_o(err_o),
      .div_o(div_o), .freq_o(freq_o)
   );

   task automatic chk(input bit good, input string req, input string what,
                      input longint unsigned act, input longint unsigned exp);
      n_chk++;
      if (!good) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   // Expected result taken from the requirements
   function automatic exp_t model(input longint unsigned v, input longint unsigned t);
      exp_t e;
      longint unsigned d;
      e.err = 1'b0; e.div = '0; e.freq = '0; e.req = ""; e.t0 = 0;
      if (t == 0 || v < t) begin e.err = 1'b1; return e; end
      d = v / t;
      if (v / d > t) d++;
      if (d > 5 && d % 2 == 1) d++;
      if (d >= 128) begin e.err = 1'b1; return e; end
      e.div  = DW'(d);
      e.freq = W'(v / d);
      return e;
   endfunction

   task automatic drain();
      while (sb.size() != 0) @(negedge clk);
   endtask

   task automatic apply(input longint unsigned v, input longint unsigned t, input string req);
      exp_t e;
      drain();
      @(negedge clk);
      e = model(v, t);
      e.req = req;
      e.t0  = cyc;
      sb.push_back(e);
      vco_i = W'(v); target_i = W'(t); start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R8", "done with no request", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(err_o == e.err && ok_o == !e.err, e.req, "err flag", err_o, e.err);
            chk(div_o == e.div, e.req, "divider", div_o, e.div);
            chk(freq_o == e.freq, e.req, "achieved freq", freq_o, e.freq);
            chk(cyc - e.t0 <= LAT_MAX + 1, "R9", "latency", cyc - e.t0 - 1, LAT_MAX);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "WATCHDOG", "run did not end", 0, 1);
      finish_run();
   end

   initial begin
      logic [W-1:0] snap_f;
      logic [DW-1:0] snap_d;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk(!done_o && !ok_o && !err_o, "R10", "flags after reset", {done_o, ok_o, err_o}, 0);
      chk(div_o == 0 && freq_o == 0, "R10", "data after reset", div_o, 0);

      apply(30, 100, "R1");
      apply(0, 1, "R1");
      apply(500, 0, "R2");
      apply(0, 0, "R2");
      apply(100, 33, "R3");
      apply(100, 30, "R3");
      apply(12, 5, "R3");
      apply(64'hFFFF_FFFF, 64'hFFFF_FFFF, "R3");
      apply(5, 1, "R4");
      apply(7, 1, "R4");
      apply(127, 1, "R5");
      apply(126, 1, "R5");
      apply(250000, 1000, "R5");
      apply(64'hFFFF_FFFF, 1, "R5");
      apply(999, 7, "R6");
      apply(64'hFFFF_FFFE, 64'h0200_0001, "R6");

      // R8: start while busy is ignored
      begin
         exp_t e;
         drain();
         @(negedge clk);
         e = model(1000, 90); e.req = "R8"; e.t0 = cyc;
         sb.push_back(e);
         vco_i = 1000; target_i = 90; start_i = 1'b1;
         @(negedge clk);
         vco_i = 30; target_i = 100;
         @(negedge clk);
         vco_i = 7; target_i = 1;
         @(negedge clk);
         start_i = 1'b0;
         drain();
         // R8: outputs hold while done is low
         snap_d = div_o; snap_f = freq_o;
         repeat (6) @(negedge clk);
         chk(div_o == snap_d && freq_o == snap_f && !done_o, "R8", "hold after done",
             freq_o, snap_f);
      end

      // Random requests near the divider limit
      for (int i = 0; i < 40; i++) begin
         longint unsigned t, k, v;
         t = $urandom_range(100000, 1);
         k = $urandom_range(140, 1);
         v = t * k + $urandom_range(32'(t - 1), 0);
         apply(v, t, "R3/R4/R5/R6");
      end
      for (int i = 0; i < 8; i++) begin
         apply($urandom, $urandom, "R1/R6");
      end

      drain();
      repeat (10) @(negedge clk);
      finish_run();
   end

endmodule